// File: doc/BRIEF.md
# Dual-Bank Recent-Requests Table

This block remembers which cache lines were requested recently, so that an offset-learning prefetcher can ask, for a candidate line, "was this line requested not long ago?". It holds two small direct-mapped banks of truncated line tags. The left bank is written with the tag of every demand access. The right bank is written when a line brought in by a hardware prefetch arrives. The value stored there is the fill tag minus the offset the prefetcher is currently using, and it is stored only while prefetch issue is turned on.

Each bank computes its own index from the tag with a shift-then-fold hash. The two banks use different shifts, so two tags that collide in one bank usually land apart in the other. A lookup probes both banks at their hashed indices in the same cycle. The hit flag comes back one cycle later and reflects the table contents as they were before any write made in the lookup's own cycle. Tag storage has no reset and is laid out for block RAM. A separate vector of valid bits is cleared by a synchronous reset.

Top module: `dual_bank_rrt`

## Requirements
- R1: After a reset, every lookup misses until a new write stores a matching tag, including a lookup of tag 0.
- R2: `lk_hit` reports the result of a lookup issued in the previous cycle. It is 0 in any cycle that does not follow a cycle with `lk_valid` high.
- R3: When `lw_valid` is high, `lw_tag` is written into the left bank at the left hash index.
- R4: The right bank is written only in a cycle where `fill_valid`, `fill_is_pf` and `pf_on` are all high. The value written is `(fill_tag - best_off) mod 2^TAG_W`.
- R5: A lookup hits when its tag equals the stored tag of a valid entry at the hashed index of either bank.
- R6: The index for bank w (left w=0, right w=1) is computed as follows: s = tag >> w, and the index is the low log2(ENTRIES) bits of s XOR (s >> log2(ENTRIES)). For the default sizes, the index is t[5:0]^t[11:6] for the left bank and t[6:1]^{1'b0,t[11:7]} for the right bank.
- R7: A write always replaces the entry at its index, which evicts the previous tag. A write to one bank never disturbs the other bank.
- R8: A left write and a right write in the same cycle both take effect.
- R9: A lookup issued in the same cycle as a write sees the contents from before that write.
- R10: Writes presented while `rst` is high are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears all valid bits |
| lw_valid | input | 1 | Demand-access write to the left bank |
| lw_tag | input | TAG_W | Tag of the demand line |
| fill_valid | input | 1 | A line fill is arriving |
| fill_is_pf | input | 1 | The fill was caused by a hardware prefetch |
| pf_on | input | 1 | Prefetch issue is currently enabled |
| fill_tag | input | TAG_W | Tag of the filled line |
| best_off | input | TAG_W | Active best offset in lines, two's complement |
| lk_valid | input | 1 | Lookup request |
| lk_tag | input | TAG_W | Tag to look up |
| lk_hit | output | 1 | Hit result for the lookup of the previous cycle |

## Verification
The bound checker watches, on every cycle, three things: that no hit appears without a lookup in the cycle before, that the first cycle out of reset carries no hit, and that a tag written into either bank is found by a lookup issued in the very next cycle, with the right-bank value taken as fill tag minus offset. Other behaviour depends on the history of the table, so only the bench's scenarios can show it. This covers eviction by a colliding tag, the differing hashes of the two banks, the gating of right-bank writes, read-before-write ordering, and writes dropped during reset. The bench compares against a reference table model driven by seeded random traffic over a small tag pool, so that collisions and hits are frequent.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
  typedef enum int unsigned {
    BANK_LEFT  = 0,
    BANK_RIGHT = 1
  } rrt_bank_e;

  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/rrt_fill_xlate.sv
module rrt_fill_xlate #(
  parameter int unsigned TAG_W = 12
) (
  input  logic             fill_valid,
  input  logic             fill_is_pf,
  input  logic             pf_on,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [TAG_W-1:0] best_off,
  output logic             wr_en,
  output logic [TAG_W-1:0] wr_tag
);
  // Right-bank writes only for prefetch fills while issue is enabled.
  always_comb begin
    wr_en  = fill_valid & fill_is_pf & pf_on;
    wr_tag = fill_tag - best_off;
  end
endmodule

// File: rtl/rrt_bank.sv
module rrt_bank #(
  parameter int unsigned TAG_W   = 12,
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned SHIFT   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             rd_en,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             hit
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  function automatic logic [IDX_W-1:0] fold(input logic [TAG_W-1:0] t);
    logic [TAG_W-1:0] s;
    logic [TAG_W-1:0] x;
    s = t >> SHIFT;
    x = s ^ (s >> IDX_W);
    return x[IDX_W-1:0];
  endfunction

  logic [TAG_W-1:0] mem [ENTRIES];
  logic [ENTRIES-1:0] vld;
  logic [IDX_W-1:0]   wr_idx, rd_idx;
  logic [TAG_W-1:0]   rd_data_q, rd_tag_q;
  logic               rd_vld_q, rd_en_q;

  assign wr_idx = fold(wr_tag);
  assign rd_idx = fold(rd_tag);

  // Tag storage: no reset, read-first, suitable for block RAM.
  always_ff @(posedge clk) begin
    if (wr_en && !rst) mem[wr_idx] <= wr_tag;
    rd_data_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= '0;
      rd_vld_q <= 1'b0;
      rd_en_q  <= 1'b0;
      rd_tag_q <= '0;
    end else begin
      if (wr_en) vld[wr_idx] <= 1'b1;
      rd_vld_q <= vld[rd_idx];
      rd_en_q  <= rd_en;
      rd_tag_q <= rd_tag;
    end
  end

  assign hit = rd_en_q & rd_vld_q & (rd_data_q == rd_tag_q);
endmodule

// File: rtl/dual_bank_rrt.sv
module dual_bank_rrt #(
  parameter int unsigned TAG_W   = 12,
  parameter int unsigned ENTRIES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lw_valid,
  input  logic [TAG_W-1:0] lw_tag,
  input  logic             fill_valid,
  input  logic             fill_is_pf,
  input  logic             pf_on,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [TAG_W-1:0] best_off,
  input  logic             lk_valid,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit
);
  import rrt_pkg::*;

  logic                 bank_wr  [NUM_BANKS];
  logic [TAG_W-1:0]     bank_tag [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_hit;
  logic                 rw_en;
  logic [TAG_W-1:0]     rw_tag;

  rrt_fill_xlate #(.TAG_W(TAG_W)) u_xlate (
    .fill_valid (fill_valid),
    .fill_is_pf (fill_is_pf),
    .pf_on      (pf_on),
    .fill_tag   (fill_tag),
    .best_off   (best_off),
    .wr_en      (rw_en),
    .wr_tag     (rw_tag)
  );

  assign bank_wr[BANK_LEFT]   = lw_valid;
  assign bank_tag[BANK_LEFT]  = lw_tag;
  assign bank_wr[BANK_RIGHT]  = rw_en;
  assign bank_tag[BANK_RIGHT] = rw_tag;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    rrt_bank #(.TAG_W(TAG_W), .ENTRIES(ENTRIES), .SHIFT(g)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (bank_wr[g]),
      .wr_tag (bank_tag[g]),
      .rd_en  (lk_valid),
      .rd_tag (lk_tag),
      .hit    (bank_hit[g])
    );
  end

  assign lk_hit = |bank_hit;
endmodule

// File: rtl/rrt_checker.sv
module rrt_checker #(
  parameter int unsigned TAG_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             lw_valid,
  input logic [TAG_W-1:0] lw_tag,
  input logic             fill_valid,
  input logic             fill_is_pf,
  input logic             pf_on,
  input logic [TAG_W-1:0] fill_tag,
  input logic [TAG_W-1:0] best_off,
  input logic             lk_valid,
  input logic [TAG_W-1:0] lk_tag,
  input logic             lk_hit
);
  logic             lw_q, rw_q;
  logic [TAG_W-1:0] lw_tag_q, rw_tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lw_q     <= 1'b0;
      rw_q     <= 1'b0;
      lw_tag_q <= '0;
      rw_tag_q <= '0;
    end else begin
      lw_q     <= lw_valid;
      rw_q     <= fill_valid && fill_is_pf && pf_on;
      lw_tag_q <= lw_tag;
      rw_tag_q <= fill_tag - best_off;
    end
  end

  p_reset_flush_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !lk_hit);

  p_idle_nohit_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(lk_valid) |-> !lk_hit);

  p_left_hit_r3: assert property (@(posedge clk) disable iff (rst)
    (lw_q && lk_valid && lk_tag == lw_tag_q) |=> lk_hit);

  p_right_hit_r4: assert property (@(posedge clk) disable iff (rst)
    (rw_q && lk_valid && lk_tag == rw_tag_q) |=> lk_hit);

  p_hit_known_r2: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(lk_hit));
endmodule

bind dual_bank_rrt rrt_checker #(.TAG_W(TAG_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lw_valid   (lw_valid),
  .lw_tag     (lw_tag),
  .fill_valid (fill_valid),
  .fill_is_pf (fill_is_pf),
  .pf_on      (pf_on),
  .fill_tag   (fill_tag),
  .best_off   (best_off),
  .lk_valid   (lk_valid),
  .lk_tag     (lk_tag),
  .lk_hit     (lk_hit)
);

// File: tb/dual_bank_rrt_bench.sv
module dual_bank_rrt_bench;
  localparam int TW = 12;
  localparam int EN = 64;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lw_valid = 0, fill_valid = 0, fill_is_pf = 0, pf_on = 0, lk_valid = 0;
  logic [TW-1:0] lw_tag = '0, fill_tag = '0, best_off = '0, lk_tag = '0;
  logic lk_hit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [TW-1:0] mL [EN];
  logic [TW-1:0] mR [EN];
  bit vL [EN];
  bit vR [EN];

  always #2 clk = ~clk;

  dual_bank_rrt #(.TAG_W(TW), .ENTRIES(EN)) u_dual_bank_rrt (
    .clk(clk), .rst(rst), .lw_valid(lw_valid), .lw_tag(lw_tag),
    .fill_valid(fill_valid), .fill_is_pf(fill_is_pf), .pf_on(pf_on),
    .fill_tag(fill_tag), .best_off(best_off), .lk_valid(lk_valid),
    .lk_tag(lk_tag), .lk_hit(lk_hit)
  );

  function automatic int hidx(input logic [TW-1:0] t, input int w);
    int s;
    s = int'(t) >> w;
    return (s ^ (s >> IW)) & (EN - 1);
  endfunction

  function automatic bit model_hit(input logic [TW-1:0] t);
    return (vL[hidx(t, 0)] && mL[hidx(t, 0)] == t) ||
           (vR[hidx(t, 1)] && mR[hidx(t, 1)] == t);
  endfunction

  task automatic clear_model();
    for (int i = 0; i < EN; i++) begin
      vL[i] = 0;
      vR[i] = 0;
      mL[i] = '0;
      mR[i] = '0;
    end
  endtask

  task automatic step(input string req, input bit lw, input logic [TW-1:0] lwt,
                      input bit fv, input bit fpf, input bit pen,
                      input logic [TW-1:0] ft, input logic [TW-1:0] bo,
                      input bit lk, input logic [TW-1:0] lkt);
    bit exp;
    logic [TW-1:0] rv;
    exp = lk && model_hit(lkt);
    if (lw) begin
      mL[hidx(lwt, 0)] = lwt;
      vL[hidx(lwt, 0)] = 1;
    end
    if (fv && fpf && pen) begin
      rv = ft - bo;
      mR[hidx(rv, 1)] = rv;
      vR[hidx(rv, 1)] = 1;
    end
    lw_valid = lw; lw_tag = lwt; fill_valid = fv; fill_is_pf = fpf;
    pf_on = pen; fill_tag = ft; best_off = bo; lk_valid = lk; lk_tag = lkt;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (lk_hit !== exp) begin
      errors++;
      $display("FAIL %s lookup %h: actual %b expected %b", req, lkt, lk_hit, exp);
    end
  endtask

  task automatic look(input string req, input logic [TW-1:0] t);
    step(req, 0, '0, 0, 0, 0, '0, '0, 1, t);
  endtask

  task automatic wl(input logic [TW-1:0] t);
    step("R3", 1, t, 0, 0, 0, '0, '0, 0, '0);
  endtask

  task automatic fill(input bit pf, input bit en, input logic [TW-1:0] ft,
                      input logic [TW-1:0] bo);
    step("R4", 0, '0, 1, pf, en, ft, bo, 0, '0);
  endtask

  // R10: writes held during reset are dropped
  task automatic do_reset(input logic [TW-1:0] junk);
    rst = 1; lw_valid = 1; lw_tag = junk; fill_valid = 1; fill_is_pf = 1;
    pf_on = 1; fill_tag = junk; best_off = '0; lk_valid = 1; lk_tag = junk;
    repeat (3) @(negedge clk);
    rst = 0; lw_valid = 0; fill_valid = 0; lk_valid = 0;
    clear_model();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    clear_model();
    @(negedge clk);
    do_reset(12'h000);
    // R1: empty after reset, including tag 0
    look("R1", 12'h000);
    look("R1", 12'hABC);
    // R2: no lookup -> no hit, even with a write
    step("R2", 1, 12'h123, 0, 0, 0, '0, '0, 0, '0);
    look("R3", 12'h123);
    // R4 gating and offset subtraction
    fill(1, 0, 12'h200, 12'h003);
    look("R4", 12'h1FD);
    fill(0, 1, 12'h200, 12'h003);
    look("R4", 12'h1FD);
    fill(1, 1, 12'h200, 12'h003);
    look("R4", 12'h1FD);
    look("R4", 12'h200);
    fill(1, 1, 12'h005, 12'h00A);
    look("R4", 12'hFFB);
    // R7: left eviction by colliding tag 0x162
    wl(12'h162);
    look("R7", 12'h123);
    look("R7", 12'h162);
    // R5: hit through right bank only
    fill(1, 1, 12'h123, 12'h000);
    look("R5", 12'h123);
    // R7: right eviction by 0x1A1, left bank untouched
    fill(1, 1, 12'h1A1, 12'h000);
    look("R7", 12'h123);
    look("R7", 12'h162);
    // R6: 0x300 and 0x341 share a left index but not a right index
    fill(1, 1, 12'h300, 12'h000);
    fill(1, 1, 12'h341, 12'h000);
    look("R6", 12'h300);
    look("R6", 12'h341);
    // R9: read-before-write
    step("R9", 1, 12'h555, 0, 0, 0, '0, '0, 1, 12'h555);
    look("R9", 12'h555);
    // R8: simultaneous writes
    step("R8", 1, 12'h777, 1, 1, 1, 12'h888, 12'h000, 0, '0);
    look("R8", 12'h777);
    look("R8", 12'h888);
    // R10 and R1: reset with writes asserted
    do_reset(12'h999);
    look("R10", 12'h999);
    look("R1", 12'h777);
    // R5: random traffic over a small tag pool
    for (int n = 0; n < 3000; n++) begin
      logic [TW-1:0] a, b, c, o;
      a = 12'($urandom_range(0, 63)) ^ 12'(($urandom_range(0, 3)) << 6);
      b = 12'($urandom_range(0, 63)) ^ 12'(($urandom_range(0, 3)) << 6);
      c = 12'($urandom_range(0, 63)) ^ 12'(($urandom_range(0, 3)) << 6);
      o = 12'($urandom_range(0, 4)) - 12'd2;
      step("R5", 1'($urandom_range(0, 1)), a, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), b, o,
           1'($urandom_range(0, 1)), c);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule